// File: doc/BRIEF.md
# Register Taint Vector Tracker

This block keeps two status bits for every architectural register while the core runs ahead in vector mode. One bit, the vector taint, says that the register's value depends on a vectorized operation. The other, the invalid taint, says the value cannot be trusted, either because an unsupported operation produced it or because one of its inputs was already unusable. For each renamed instruction the block reads the bits of up to two source registers and merges them by OR. It then classifies the instruction as a vector issue, a scalar issue or a drop, and writes the merged bits to the destination register on the next clock edge.

An instruction that loads with a detected stride starts vector mode and seeds the vector taint on its destination. Any operation class the vector path cannot handle seeds the invalid taint. A clear input wipes the whole table when the core enters vector-runahead mode. The classification comes out combinationally in the same cycle as the instruction. The table update becomes visible to the following cycle's instruction.

Top module: `taint_vector_tracker`

## Requirements
- R1: After a synchronous active-low reset every register's bits are zero, so an instruction of class plain (code 2'b00) reading any registers issues as scalar with merged bits 2'b00.
- R2: The merged bits `dst_taint_o` (bit 0 vector, bit 1 invalid) are the OR of the bits of every source whose valid flag is high, plus the op-class seed. A source whose valid flag is low contributes nothing. These bits are written to the destination register and can be read back on the next cycle.
- R3: Op class striding load (code 2'b01) sets the vector bit of the merged bits, and the instruction is never issued as scalar.
- R4: Op class unsupported (codes 2'b10 and 2'b11) sets the invalid bit of the merged bits, and the instruction is dropped.
- R5: If any valid source carries the invalid bit, the instruction is dropped, even when its vector bit is also set.
- R6: A valid instruction raises exactly one of `vec_issue_o`, `scalar_issue_o` and `drop_o`: vector when the merged vector bit is set and the invalid bit is clear, scalar when neither bit is set. With `inst_valid_i` low all three stay low.
- R7: An instruction with `dst_valid_i` low, or any cycle with `inst_valid_i` low, leaves the table unchanged.
- R8: `clear_i` zeroes every entry on that clock edge and overrides a write in the same cycle. The instruction presented in that cycle is still classified from the old contents.
- R9: When an instruction names the same register as source and destination, it is classified from the old value. The new value is seen by the instruction in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Zero the table on mode entry |
| inst_valid_i | input | 1 | An instruction is presented this cycle |
| op_class_i | input | 2 | 00 plain, 01 striding load, 10/11 unsupported |
| src0_valid_i | input | 1 | First source is used |
| src0_idx_i | input | 5 | First source register index |
| src1_valid_i | input | 1 | Second source is used |
| src1_idx_i | input | 5 | Second source register index |
| dst_valid_i | input | 1 | Instruction writes a destination |
| dst_idx_i | input | 5 | Destination register index |
| vec_issue_o | output | 1 | Issue as vector operation |
| scalar_issue_o | output | 1 | Issue as scalar operation |
| drop_o | output | 1 | Instruction is invalid and not issued |
| dst_taint_o | output | 2 | Merged bits {invalid, vector} |

## Verification
The assertions assume that every control input is driven to a known 0 or 1 from the first clock edge, and that at most one instruction is presented per cycle. They also assume the indices stay below the register count. The bench drives all inputs to zero before reset is released. It changes them only at falling edges, and it draws indices only from the 5-bit range of the 32-entry table. Random traffic mixes all four op-class codes, missing sources and missing destinations, and issues occasional clears, so the OR merging and the drop priority are reached along long dependency chains. Directed cases cover read-before-write on the same register and a clear that collides with a write.

// File: rtl/tvt_pkg.sv
// Package: shared types of the register taint tracker.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package tvt_pkg;

    // Two status bits per register; bit 0 vector, bit 1 invalid.
    typedef struct packed {
        logic inval;
        logic vec;
    } taint_t;

    // Operation class as presented by rename.
    typedef enum logic [1:0] {
        OP_PLAIN   = 2'b00,
        OP_STRIDE  = 2'b01,
        OP_UNSUP_A = 2'b10,
        OP_UNSUP_B = 2'b11
    } op_class_e;

    // Outcome of classification.
    typedef enum logic [1:0] {
        OUT_NONE   = 2'b00,
        OUT_SCALAR = 2'b01,
        OUT_VECTOR = 2'b10,
        OUT_DROP   = 2'b11
    } outcome_e;

endpackage

// File: rtl/tvt_table.sv
// Module: taint storage, one 2-bit entry per architectural register.
// Two combinational read ports, one synchronous write port, and a
// synchronous clear that beats the write. Assumes indices < NUM_REGS.
module tvt_table
    import tvt_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  taint_t           wr_bits_i,
    input  logic [IDX_W-1:0] rd0_idx_i,
    output taint_t           rd0_bits_o,
    input  logic [IDX_W-1:0] rd1_idx_i,
    output taint_t           rd1_bits_o
);

    taint_t entries [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        // Hold one register's bits: reset/clear to zero, else take a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                entries[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                entries[g] <= wr_bits_i;
            end
        end

        // R8: a clear leaves this entry zero on the following cycle.
        assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
            clear_i |=> (entries[g] == '0));

        // R7: with no write aimed here and no clear, the entry keeps its value.
        assert_untouched_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear_i && !(wr_en_i && (wr_idx_i == IDX_W'(g)))) |=> $stable(entries[g]));
    end

    // Read both source entries without delay.
    always_comb begin
        rd0_bits_o = entries[rd0_idx_i];
        rd1_bits_o = entries[rd1_idx_i];
    end

    // R2: an accepted write is found in the addressed entry one cycle later.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clear_i) |=> (entries[$past(wr_idx_i)] == $past(wr_bits_i)));

endmodule

// File: rtl/tvt_classify.sv
// Module: merges source taint with the op-class seed and picks an outcome.
// Purely combinational. Assumes source bits come from the table read ports.
module tvt_classify
    import tvt_pkg::*;
(
    input  logic      inst_valid_i,
    input  op_class_e op_class_i,
    input  logic      src0_valid_i,
    input  taint_t    src0_bits_i,
    input  logic      src1_valid_i,
    input  taint_t    src1_bits_i,
    output taint_t    merged_o,
    output outcome_e  outcome_o
);

    taint_t src_or;

    // OR the bits of the sources that are in use.
    always_comb begin
        src_or = '0;
        if (src0_valid_i) src_or = src_or | src0_bits_i;
        if (src1_valid_i) src_or = src_or | src1_bits_i;
    end

    // Add the op-class seed: stride load taints vector, unsupported taints invalid.
    always_comb begin
        merged_o       = src_or;
        merged_o.vec   = src_or.vec   | (op_class_i == OP_STRIDE);
        merged_o.inval = src_or.inval | op_class_i[1];
    end

    // Choose the outcome: invalid wins, then vector, else scalar.
    always_comb begin
        if (!inst_valid_i)       outcome_o = OUT_NONE;
        else if (merged_o.inval) outcome_o = OUT_DROP;
        else if (merged_o.vec)   outcome_o = OUT_VECTOR;
        else                     outcome_o = OUT_SCALAR;
    end

endmodule

// File: rtl/taint_vector_tracker.sv
// Module: top of the register taint tracker used during vector runahead.
// Classifies one renamed instruction per cycle and updates the destination
// entry at the next edge. Assumes one instruction per cycle, known inputs.
module taint_vector_tracker
    import tvt_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inst_valid_i,
    input  logic [1:0]       op_class_i,
    input  logic             src0_valid_i,
    input  logic [IDX_W-1:0] src0_idx_i,
    input  logic             src1_valid_i,
    input  logic [IDX_W-1:0] src1_idx_i,
    input  logic             dst_valid_i,
    input  logic [IDX_W-1:0] dst_idx_i,
    output logic             vec_issue_o,
    output logic             scalar_issue_o,
    output logic             drop_o,
    output logic [1:0]       dst_taint_o
);

    taint_t   rd0_bits;
    taint_t   rd1_bits;
    taint_t   merged;
    outcome_e outcome;
    logic     wr_en;

    tvt_table #(.NUM_REGS(NUM_REGS)) table_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .wr_en_i    (wr_en),
        .wr_idx_i   (dst_idx_i),
        .wr_bits_i  (merged),
        .rd0_idx_i  (src0_idx_i),
        .rd0_bits_o (rd0_bits),
        .rd1_idx_i  (src1_idx_i),
        .rd1_bits_o (rd1_bits)
    );

    tvt_classify classify_i (
        .inst_valid_i (inst_valid_i),
        .op_class_i   (op_class_e'(op_class_i)),
        .src0_valid_i (src0_valid_i),
        .src0_bits_i  (rd0_bits),
        .src1_valid_i (src1_valid_i),
        .src1_bits_i  (rd1_bits),
        .merged_o     (merged),
        .outcome_o    (outcome)
    );

    // Write only for a valid instruction that names a destination.
    always_comb wr_en = inst_valid_i && dst_valid_i;

    // Decode the outcome onto the issue outputs.
    always_comb begin
        vec_issue_o    = (outcome == OUT_VECTOR);
        scalar_issue_o = (outcome == OUT_SCALAR);
        drop_o         = (outcome == OUT_DROP);
        dst_taint_o    = merged;
    end

    // R6: a valid instruction gets exactly one outcome.
    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inst_valid_i |-> ($countones({vec_issue_o, scalar_issue_o, drop_o}) == 1));

    // R6: no instruction, no outcome.
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inst_valid_i |-> !(vec_issue_o || scalar_issue_o || drop_o));

    // R4: an unsupported class is always dropped.
    assert_unsup_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid_i && op_class_i[1]) |-> (drop_o && dst_taint_o[1]));

    // R3: a striding load is never issued as scalar.
    assert_stride_not_scalar_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid_i && (op_class_i == 2'b01)) |-> (!scalar_issue_o && dst_taint_o[0]));

    // R5: an invalid source read from the table forces a drop.
    assert_bad_source_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid_i && ((src0_valid_i && rd0_bits.inval) || (src1_valid_i && rd1_bits.inval)))
        |-> drop_o);

endmodule

// File: tb/taint_vector_tracker_tb_top.sv
// Bench: directed corners then seeded random traffic against a bench model.
module taint_vector_tracker_tb_top;

    localparam int NREG = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       inst_valid_i = 1'b0;
    logic [1:0] op_class_i = 2'b00;
    logic       src0_valid_i = 1'b0;
    logic [4:0] src0_idx_i = '0;
    logic       src1_valid_i = 1'b0;
    logic [4:0] src1_idx_i = '0;
    logic       dst_valid_i = 1'b0;
    logic [4:0] dst_idx_i = '0;
    logic       vec_issue_o, scalar_issue_o, drop_o;
    logic [1:0] dst_taint_o;

    int checks = 0;
    int failures = 0;
    logic [1:0] model [NREG];
    bit done = 1'b0;

    taint_vector_tracker dut_i (.*);

    always #10 clk = ~clk;   // 50 MHz

    // Expected merged bits {invalid, vector}.
    function automatic logic [1:0] exp_bits(logic [1:0] oc, logic v0, logic [4:0] i0,
                                            logic v1, logic [4:0] i1);
        logic [1:0] b = 2'b00;
        if (v0) b = b | model[i0];
        if (v1) b = b | model[i1];
        if (oc == 2'b01) b[0] = 1'b1;
        if (oc[1]) b[1] = 1'b1;
        return b;
    endfunction

    // Expected {vec, scalar, drop} for a valid instruction.
    function automatic logic [2:0] exp_out(logic [1:0] b);
        if (b[1]) return 3'b001;
        if (b[0]) return 3'b100;
        return 3'b010;
    endfunction

    task automatic check(bit ok, string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Present one cycle of stimulus, check outputs, then advance the model.
    task automatic step(bit iv, logic [1:0] oc, bit v0, logic [4:0] i0, bit v1,
                        logic [4:0] i1, bit dv, logic [4:0] di, bit clr, string req);
        logic [1:0] eb;
        logic [2:0] eo;
        inst_valid_i = iv; op_class_i = oc;
        src0_valid_i = v0; src0_idx_i = i0;
        src1_valid_i = v1; src1_idx_i = i1;
        dst_valid_i = dv; dst_idx_i = di; clear_i = clr;
        #5;
        eb = exp_bits(oc, v0, i0, v1, i1);
        eo = iv ? exp_out(eb) : 3'b000;
        check({vec_issue_o, scalar_issue_o, drop_o} == eo && (!iv || dst_taint_o == eb), req,
              {vec_issue_o, scalar_issue_o, drop_o, dst_taint_o},
              {eo, (iv ? eb : dst_taint_o)});
        @(posedge clk);
        if (clr) begin
            for (int k = 0; k < NREG; k++) model[k] = 2'b00;
        end else if (iv && dv) begin
            model[di] = eb;
        end
        @(negedge clk);
    endtask

    // Read one register through a plain op with no destination.
    task automatic probe(logic [4:0] r, string req);
        step(1'b1, 2'b00, 1'b1, r, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, req);
    endtask

    initial begin
        for (int k = 0; k < NREG; k++) model[k] = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, probe a spread of registers.
        for (int r = 0; r < NREG; r += 7) probe(5'(r), "R1 reset zero");
        // R6: idle cycle produces no outcome.
        step(1'b0, 2'b01, 1'b1, 5'd1, 1'b0, 5'd0, 1'b1, 5'd3, 1'b0, "R6 idle quiet");
        probe(5'd3, "R7 idle wrote nothing");
        // R3: stride seed on r4, then dependent use.
        step(1'b1, 2'b01, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd4, 1'b0, "R3 stride seed");
        step(1'b1, 2'b00, 1'b1, 5'd4, 1'b1, 5'd9, 1'b1, 5'd5, 1'b0, "R2 vector propagates");
        // R2: unused source ignored even when tainted.
        step(1'b1, 2'b00, 1'b0, 5'd4, 1'b1, 5'd9, 1'b1, 5'd6, 1'b0, "R2 unused source");
        // R4: unsupported op, both encodings.
        step(1'b1, 2'b10, 1'b1, 5'd9, 1'b0, 5'd0, 1'b1, 5'd7, 1'b0, "R4 unsupported 10");
        step(1'b1, 2'b11, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd8, 1'b0, "R4 unsupported 11");
        // R5: invalid plus vector sources still dropped.
        step(1'b1, 2'b00, 1'b1, 5'd7, 1'b1, 5'd5, 1'b1, 5'd10, 1'b0, "R5 invalid beats vector");
        // R7: no destination leaves table unchanged.
        step(1'b1, 2'b01, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd11, 1'b0, "R7 no dst");
        probe(5'd11, "R7 no dst left clean");
        // R9: same register read then written.
        step(1'b1, 2'b01, 1'b1, 5'd12, 1'b0, 5'd0, 1'b1, 5'd12, 1'b0, "R9 old value used");
        probe(5'd12, "R9 new value seen");
        // R8: clear colliding with a write.
        step(1'b1, 2'b10, 1'b1, 5'd4, 1'b0, 5'd0, 1'b1, 5'd13, 1'b1, "R8 classify before clear");
        probe(5'd13, "R8 clear beats write");
        probe(5'd4, "R8 clear wipes");
        // Seeded random traffic.
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] oc;
            int w;
            w = $urandom_range(0, 9);
            oc = (w < 5) ? 2'b00 : (w < 8) ? 2'b01 : 2'($urandom_range(2, 3));
            step($urandom_range(0, 9) != 0, oc,
                 1'($urandom), 5'($urandom), 1'($urandom), 5'($urandom),
                 $urandom_range(0, 4) != 0, 5'($urandom),
                 $urandom_range(0, 59) == 0, "R2/R3/R4/R5/R6 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule